// File: doc/BRIEF.md
# Tiled Surface Address Walker

This block walks a rectangular region of a two-dimensional surface and emits, one pixel per accepted cycle, the byte address of each pixel in the surface's memory layout. The surface may be stored linearly or in one of three 4 KiB tiled layouts: a wide, short tile (512 bytes by 8 rows), a narrow, tall tile (128 bytes by 32 rows) whose 16-byte units are ordered column-first, and a square 64 by 64 tile built from nested 8x8, 4x4 and 2x2 blocks. For the tiled layouts an optional bit-6 address swizzle can be applied.

A command gives the region origin (x in bytes, y in rows), its width and height in pixels, the pixel size in bytes, the row pitch in bytes, the layout and the swizzle enable. All of these are captured when the command is accepted. Addresses leave through a valid/ready handshake, and a one-cycle done pulse marks the end of the region.

Top module: `tile_addr_walker`

## Requirements
- R1: With `tmode` = 0 (linear) the address is y*pitch + x, and the swizzle enable has no effect.
- R2: With `tmode` = 1 (wide tile) the address is ((y/8)*(pitch/512) + x/512)*4096 + (y%8)*512 + x%512.
- R3: With `tmode` = 2 (tall tile) the address is ((y/32)*(pitch/128) + x/128)*4096 + (((x%128)/16)*32 + y%32)*16 + x%16.
- R4: With `tmode` = 3 (square tile), using xi = x%64 and yi = y%64, the address is ((y/64)*(pitch/64) + x/64)*4096 + ((xi/8)*8 + yi/8)*64 + (bit2(yi)*2+bit2(xi))*16 + (bit1(yi)*2+bit1(xi))*4 + bit0(yi)*2+bit0(xi).
- R5: With `swz_en` = 1 and `tmode` = 1, address bit 6 is replaced by bit6 XOR bit9 XOR bit10 of the unswizzled address.
- R6: With `swz_en` = 1 and `tmode` = 2 or 3, address bit 6 is replaced by bit6 XOR bit9 of the unswizzled address.
- R7: Pixels are emitted row by row: within a row x steps by `bpp`, after each row y steps by one and x returns to the origin, for exactly width*height addresses.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` holds its value.
- R9: `done` is a single-cycle pulse high in the same cycle as the handshake of the final address; `out_valid` is low in the following cycle.
- R10: A command with zero width or zero height emits no address and raises `done` for one cycle, in the cycle after it is accepted.
- R11: A `start` while a walk is in progress is ignored; the current walk continues unchanged.
- R12: The first address is valid in the cycle after `start` is accepted, and pitch, layout and swizzle enable are taken from that cycle only; later changes on those inputs do not affect the walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted when idle |
| org_x | input | 16 | Region origin x in bytes |
| org_y | input | 16 | Region origin y in rows |
| width | input | 12 | Region width in pixels |
| height | input | 12 | Region height in rows |
| bpp | input | 4 | Bytes per pixel |
| pitch | input | 16 | Surface row pitch in bytes |
| tmode | input | 2 | Layout: 0 linear, 1 wide tile, 2 tall tile, 3 square tile |
| swz_en | input | 1 | Bit-6 swizzle enable for tiled layouts |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Consumer accepts the address |
| out_addr | output | 32 | Byte address of the current pixel |
| done | output | 1 | One-cycle end-of-region pulse |

## Verification
The assertions assume the pitch is a multiple of the selected tile width and that the region's byte coordinates fit in 32 bits; the bench keeps a 1024-byte pitch and small origins placed just before tile edges so every walk crosses tile rows and columns. They also take `out_ready` to be arbitrary, so the bench drives a periodic stall pattern and checks that a stalled address holds. Commands that arrive mid-walk and layout or pitch changes after acceptance are injected deliberately to show they leave the walk untouched.

// File: rtl/tile_walk_pkg.sv
package tile_walk_pkg;

    localparam int ADDR_W    = 32;
    localparam int TILE_LG2  = 12;

    typedef enum logic [1:0] {
        TM_LINEAR = 2'd0,
        TM_WIDE   = 2'd1,
        TM_TALL   = 2'd2,
        TM_SQUARE = 2'd3
    } tile_mode_t;

    typedef struct packed {
        tile_mode_t         mode;
        logic               swz;
        logic [ADDR_W-1:0]  pitch;
    } surf_cfg_t;

    // Wide tile: 512 B x 8 rows, row-major bytes.
    function automatic logic [ADDR_W-1:0] wide_addr(input logic [ADDR_W-1:0] x,
                                                    input logic [ADDR_W-1:0] y,
                                                    input logic [ADDR_W-1:0] tpr);
        logic [ADDR_W-1:0] t;
        t = (y >> 3) * tpr + (x >> 9);
        return {t[ADDR_W-TILE_LG2-1:0], y[2:0], x[8:0]};
    endfunction

    // Tall tile: 128 B x 32 rows, 16-byte units column-major.
    function automatic logic [ADDR_W-1:0] tall_addr(input logic [ADDR_W-1:0] x,
                                                    input logic [ADDR_W-1:0] y,
                                                    input logic [ADDR_W-1:0] tpr);
        logic [ADDR_W-1:0] t;
        t = (y >> 5) * tpr + (x >> 7);
        return {t[ADDR_W-TILE_LG2-1:0], x[6:4], y[4:0], x[3:0]};
    endfunction

    // Square tile: 64 x 64, 8x8 blocks column-major, nested sub-blocks row-major.
    function automatic logic [ADDR_W-1:0] square_addr(input logic [ADDR_W-1:0] x,
                                                      input logic [ADDR_W-1:0] y,
                                                      input logic [ADDR_W-1:0] tpr);
        logic [ADDR_W-1:0] t;
        t = (y >> 6) * tpr + (x >> 6);
        return {t[ADDR_W-TILE_LG2-1:0], x[5:3], y[5:3],
                y[2], x[2], y[1], x[1], y[0], x[0]};
    endfunction

    // Bit-6 swizzle; the wide layout also folds in bit 10.
    function automatic logic [ADDR_W-1:0] swizzle6(input logic [ADDR_W-1:0] a,
                                                   input logic three_way);
        logic nb;
        nb = a[6] ^ a[9] ^ (three_way & a[10]);
        return {a[ADDR_W-1:7], nb, a[5:0]};
    endfunction

endpackage

// File: rtl/tw_addr.sv
module tw_addr
    import tile_walk_pkg::*;
#(
    parameter bit HAS_SWIZZLE = 1'b1
) (
    input  surf_cfg_t          cfg,
    input  logic [ADDR_W-1:0]  cur_x,
    input  logic [ADDR_W-1:0]  cur_y,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] raw;

    always_comb begin
        unique case (cfg.mode)
            TM_WIDE:   raw = wide_addr(cur_x, cur_y, cfg.pitch >> 9);
            TM_TALL:   raw = tall_addr(cur_x, cur_y, cfg.pitch >> 7);
            TM_SQUARE: raw = square_addr(cur_x, cur_y, cfg.pitch >> 6);
            default:   raw = cur_y * cfg.pitch + cur_x;
        endcase
    end

    generate
        if (HAS_SWIZZLE) begin : g_swz
            always_comb begin
                if (cfg.swz && cfg.mode != TM_LINEAR)
                    addr = swizzle6(raw, cfg.mode == TM_WIDE);
                else
                    addr = raw;
            end
        end else begin : g_noswz
            logic unused_swz;
            assign unused_swz = cfg.swz;
            assign addr = raw;
        end
    endgenerate

endmodule

// File: rtl/tw_seq.sv
module tw_seq
    import tile_walk_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int DIM_W   = 12,
    parameter int BPP_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    input  logic [BPP_W-1:0]   bpp,
    input  logic               ready,
    output logic               valid,
    output logic               done,
    output logic               load,
    output logic [ADDR_W-1:0]  cur_x,
    output logic [ADDR_W-1:0]  cur_y
);
    localparam int XPAD = ADDR_W - COORD_W;
    localparam int BPAD = ADDR_W - BPP_W;

    logic               busy;
    logic               zdone;
    logic [DIM_W-1:0]   col, row, w_q, h_q;
    logic [BPP_W-1:0]   bpp_q;
    logic [ADDR_W-1:0]  ox_q;
    logic               zero_sz, accept, fire, row_end, last;

    assign zero_sz = (width == '0) || (height == '0);
    assign accept  = start && !busy;
    assign load    = accept;
    assign fire    = busy && ready;
    assign row_end = (col == w_q - 1'b1);
    assign last    = row_end && (row == h_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            zdone <= 1'b0;
            col   <= '0;
            row   <= '0;
            w_q   <= '0;
            h_q   <= '0;
            bpp_q <= '0;
            ox_q  <= '0;
            cur_x <= '0;
            cur_y <= '0;
        end else begin
            zdone <= accept && zero_sz;
            if (accept && !zero_sz) begin
                busy  <= 1'b1;
                col   <= '0;
                row   <= '0;
                w_q   <= width;
                h_q   <= height;
                bpp_q <= bpp;
                ox_q  <= {{XPAD{1'b0}}, org_x};
                cur_x <= {{XPAD{1'b0}}, org_x};
                cur_y <= {{XPAD{1'b0}}, org_y};
            end else if (fire) begin
                if (last) begin
                    busy <= 1'b0;
                end else if (row_end) begin
                    col   <= '0;
                    row   <= row + 1'b1;
                    cur_x <= ox_q;
                    cur_y <= cur_y + 1'b1;
                end else begin
                    col   <= col + 1'b1;
                    cur_x <= cur_x + {{BPAD{1'b0}}, bpp_q};
                end
            end
        end
    end

    assign valid = busy;
    assign done  = (fire && last) || zdone;

    p_in_bounds_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (col < w_q) && (row < h_q));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !valid);

    p_zero_region_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && zero_sz) |=> (done && !valid));

    p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !ready) |=> (busy && $stable(cur_x) && $stable(cur_y)));

    p_first_valid_r12: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !zero_sz) |=> valid);

endmodule

// File: rtl/tile_addr_walker.sv
module tile_addr_walker
    import tile_walk_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int DIM_W   = 12,
    parameter int BPP_W   = 4,
    parameter int PITCH_W = 16,
    parameter bit HAS_SWIZZLE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [DIM_W-1:0]   width,
    input  logic [DIM_W-1:0]   height,
    input  logic [BPP_W-1:0]   bpp,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [1:0]         tmode,
    input  logic               swz_en,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               done
);
    localparam int PPAD = ADDR_W - PITCH_W;

    surf_cfg_t          cfg_q;
    logic               load;
    logic [ADDR_W-1:0]  cur_x, cur_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q.mode  <= tile_mode_t'(tmode);
            cfg_q.swz   <= swz_en;
            cfg_q.pitch <= {{PPAD{1'b0}}, pitch};
        end
    end

    tw_seq #(
        .COORD_W (COORD_W),
        .DIM_W   (DIM_W),
        .BPP_W   (BPP_W)
    ) i_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .org_x  (org_x),
        .org_y  (org_y),
        .width  (width),
        .height (height),
        .bpp    (bpp),
        .ready  (out_ready),
        .valid  (out_valid),
        .done   (done),
        .load   (load),
        .cur_x  (cur_x),
        .cur_y  (cur_y)
    );

    tw_addr #(
        .HAS_SWIZZLE (HAS_SWIZZLE)
    ) i_addr (
        .cfg   (cfg_q),
        .cur_x (cur_x),
        .cur_y (cur_y),
        .addr  (out_addr)
    );

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !load) |=> $stable(cfg_q));

endmodule

// File: tb/test_tile_addr_walker.sv
module test_tile_addr_walker;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] org_x, org_y;
    logic [11:0] width, height;
    logic [3:0]  bpp;
    logic [15:0] pitch;
    logic [1:0]  tmode;
    logic        swz_en;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_addr;
    logic        done;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    tile_addr_walker i_tile_addr_walker (
        .clk(clk), .rst(rst), .start(start), .org_x(org_x), .org_y(org_y),
        .width(width), .height(height), .bpp(bpp), .pitch(pitch),
        .tmode(tmode), .swz_en(swz_en), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic longint unsigned ref_addr(input int m, input bit s, input longint unsigned p,
                                                 input longint unsigned x, input longint unsigned y);
        longint unsigned a, xi, yi, b6, nb;
        case (m)
            1: a = ((y / 8) * (p / 512) + x / 512) * 4096 + (y % 8) * 512 + x % 512;
            2: a = ((y / 32) * (p / 128) + x / 128) * 4096
                   + (((x % 128) / 16) * 32 + y % 32) * 16 + x % 16;
            3: begin
                xi = x % 64; yi = y % 64;
                a = ((y / 64) * (p / 64) + x / 64) * 4096 + ((xi / 8) * 8 + yi / 8) * 64
                    + (((yi / 4) % 2) * 2 + (xi / 4) % 2) * 16
                    + (((yi / 2) % 2) * 2 + (xi / 2) % 2) * 4
                    + (yi % 2) * 2 + xi % 2;
            end
            default: a = y * p + x;
        endcase
        a = a % 64'h1_0000_0000;
        if (s && m != 0) begin
            b6 = (a / 64) % 2;
            nb = b6 ^ ((a / 512) % 2);
            if (m == 1) nb = nb ^ ((a / 1024) % 2);
            a = a - b6 * 64 + nb * 64;
        end
        return a;
    endfunction

    function automatic string req_of(input int m, input bit s);
        if (s && m == 1) return "R5";
        if (s && m >= 2) return "R6";
        case (m)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R1";
        endcase
    endfunction

    // Walk one region with a stall pattern, a busy-time start and input churn.
    task automatic walk(input int m, input bit s, input int ox, input int oy,
                        input int w, input int h, input int b, input int stall_mod);
        int k = 0;
        int cyc = 0;
        int total = w * h;
        bit stalled = 1'b0;
        logic [31:0] held = '0;
        @(negedge clk);
        start = 1'b1; org_x = 16'(ox); org_y = 16'(oy); width = 12'(w); height = 12'(h);
        bpp = 4'(b); pitch = 16'd1024; tmode = 2'(m); swz_en = s;
        @(negedge clk);
        start = 1'b0;
        tmode = 2'(3 - m); swz_en = !s; pitch = 16'd512; // R12: ignored after accept
        org_x = 16'd7; org_y = 16'd9;
        while (k < total && cyc < 2000) begin
            if (cyc > 0) @(negedge clk);
            start = (cyc == 3);                    // R11: start during a walk
            out_ready = ((cyc % stall_mod) != 1);
            #5;
            if (cyc == 0) check(out_valid === 1'b1, "R12", out_valid, 1);
            if (stalled) check(out_addr === held, "R8", out_addr, held);
            if (out_valid) begin
                if (out_ready) begin
                    longint unsigned ex = ref_addr(m, s, 1024,
                        longint'(ox + (k % w) * b), longint'(oy + k / w));
                    check(out_addr === 32'(ex), req_of(m, s), out_addr, ex);
                    check(done === (k == total - 1), (k == total - 1) ? "R9" : "R7",
                          done, (k == total - 1));
                    k++;
                    stalled = 1'b0;
                end else begin
                    stalled = 1'b1;
                    held = out_addr;
                end
            end else begin
                check(1'b0, "R7", out_valid, 1);
            end
            cyc++;
        end
        start = 1'b0;
        check(k == total, "R7", k, total);
        @(negedge clk); #5;
        check(out_valid === 1'b0, "R9", out_valid, 0);
        check(done === 1'b0, "R9", done, 0);
        out_ready = 1'b0;
    endtask

    task automatic zero_walk(input int w, input int h);
        @(negedge clk);
        start = 1'b1; width = 12'(w); height = 12'(h); org_x = 16'd4; org_y = 16'd4;
        @(negedge clk);
        start = 1'b0;
        #5;
        check(done === 1'b1, "R10", done, 1);
        check(out_valid === 1'b0, "R10", out_valid, 0);
        @(negedge clk); #5;
        check(done === 1'b0, "R10", done, 0);
        check(out_valid === 1'b0, "R10", out_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; org_x = '0; org_y = '0; width = '0; height = '0;
        bpp = '0; pitch = '0; tmode = '0; swz_en = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        check(out_valid === 1'b0, "R9", out_valid, 0);
        check(done === 1'b0, "R9", done, 0);

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                walk(m, s[0], 496, 6, 6, 5, 4, 3);
                walk(m, s[0], 120, 29, 9, 4, 1, 4);
                walk(m, s[0], 60, 62, 5, 6, 2, 5);
                walk(m, s[0], 1000, 1534, 7, 3, 8, 7);
            end
        end
        zero_walk(0, 5);
        zero_walk(5, 0);
        zero_walk(0, 0);
        walk(2, 1'b1, 0, 0, 1, 1, 1, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule